// File: doc/BRIEF.md
# Semaphore-Guarded Shared-Memory Crossbar

This block lets several processing units share a set of memory blocks. Each block is guarded by its own one-bit hardware semaphore. A unit must first claim a block with an atomic test-and-lock operation. Once it holds the block, its reads and writes are routed to that block's RAM. When it has finished, it frees the semaphore. The lock operation reports success or failure one cycle later, and a unit that fails simply retries.

Units that hold different blocks reach them in the same cycle with no interaction. When several units try to claim the same free block in one cycle, a fixed priority decides: the unit with the lowest index wins. Any access or release attempted by a unit that does not hold the addressed block is dropped and flagged to that unit as a protocol error. Each memory block is modelled as a simple synchronous RAM.

Each unit presents four things every cycle:
- a 2-bit operation code, with IDLE=0, LOCK=1, FREE=2 and ACCESS=3;
- a block select;
- a word address;
- a write enable together with write data.

Top module: `sem_xbar`

## Requirements
- R1: During and after synchronous reset, the outputs lock_ack, lock_ok, prot_err and rd_valid are 0 and all semaphores are free, so a LOCK from any unit, including the lowest-priority one, succeeds on every block.
- R2: A LOCK (op code 1) on a free block, with no lower-index unit locking the same block in that cycle, raises lock_ack and lock_ok for that unit in the following cycle, and the unit then holds the block.
- R3: A LOCK on a block that is already held fails: lock_ack=1 and lock_ok=0 in the next cycle. This holds even when the requester is the current holder, and the holder does not change.
- R4: When several units LOCK the same free block in one cycle, only the lowest-index unit gets lock_ok; all the others see lock_ok=0.
- R5: A FREE (op code 2) by the holder releases the block at once, so a LOCK in a later cycle can succeed. A FREE by a non-holder leaves the semaphore unchanged and raises prot_err for that unit in the next cycle.
- R6: An ACCESS (op code 3) by the holder writes unit_wdata when unit_we=1. When unit_we=0, it reads, and rd_valid and rd_data are returned in the next cycle. Only the low MEM_AW bits of unit_addr index the RAM.
- R7: An ACCESS to a block the unit does not hold has no effect on memory and produces no rd_valid. It raises prot_err for that unit in the next cycle.
- R8: Units holding different blocks can read or write them in the same cycle, and each gets its own data.
- R9: One unit may hold several blocks at once and may access each of them.
- R10: unit_sel value b addresses semaphore b and RAM block b (8 blocks by default). Locking or releasing one block does not affect any other block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_op | input | N_UNITS x 2 | Operation per unit: 0 idle, 1 lock, 2 free, 3 access |
| unit_sel | input | N_UNITS x 3 | Target block per unit |
| unit_addr | input | N_UNITS x 16 | Word address per unit |
| unit_we | input | N_UNITS | Write enable for an access |
| unit_wdata | input | N_UNITS x 32 | Write data per unit |
| lock_ack | output | N_UNITS | A lock attempt was evaluated last cycle |
| lock_ok | output | N_UNITS | That lock attempt succeeded |
| prot_err | output | N_UNITS | Access or release by a non-holder last cycle |
| rd_valid | output | N_UNITS | Read data valid |
| rd_data | output | N_UNITS x 32 | Read data from the accessed block |

## Verification
Lock contention is driven with four distinct patterns:
- all four units on one block, which exposes the priority order;
- a subset of units on one block, which shows that a non-zero unit can win when unit 0 is absent;
- units on distinct blocks, which shows per-block independence;
- a claim on a block released in the same cycle or earlier, which separates release timing from lock evaluation.

Data traffic is checked in three ways:
- concurrent writes and reads by holders of separate blocks, with addresses whose upper bits differ, to prove that only the low bits index the RAM;
- foreign writes, followed by a read from the holder, to catch a write that leaks through;
- releases and accesses by non-holders on free and held blocks, to confirm that the error flag and the semaphore state stay separate.

// File: rtl/sem_xbar_pkg.sv
package sem_xbar_pkg;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_LOCK   = 2'd1,
        OP_FREE   = 2'd2,
        OP_ACCESS = 2'd3
    } xop_e;

    function automatic logic op_is(input logic [1:0] raw, input xop_e kind);
        return raw == kind;
    endfunction

endpackage

// File: rtl/sem_xbar_sem_bank.sv
module sem_xbar_sem_bank
    import sem_xbar_pkg::*;
#(
    parameter int N_UNITS  = 4,
    parameter int N_BLOCKS = 8,
    localparam int UW = $clog2(N_UNITS),
    localparam int SW = $clog2(N_BLOCKS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [N_UNITS-1:0][1:0]           op,
    input  logic [N_UNITS-1:0][SW-1:0]        sel,
    output logic [N_BLOCKS-1:0]               held,
    output logic [N_BLOCKS-1:0][UW-1:0]       owner,
    output logic [N_UNITS-1:0]                lock_ok_q,
    output logic [N_UNITS-1:0]                free_bad
);

    logic [N_BLOCKS-1:0]         any_req;
    logic [N_BLOCKS-1:0]         rel;
    logic [N_BLOCKS-1:0][UW-1:0] win;
    logic [N_UNITS-1:0]          grant_now;

    // Per block: find the lowest-index lock requester (fixed priority)
    always_comb begin
        any_req = '0;
        win     = '0;
        for (int b = 0; b < N_BLOCKS; b++) begin
            for (int u = N_UNITS - 1; u >= 0; u--) begin
                if (op_is(op[u], OP_LOCK) && sel[u] == SW'(b)) begin
                    any_req[b] = 1'b1;
                    win[b]     = UW'(u);
                end
            end
        end
    end

    // Releases are honoured only from the current holder
    always_comb begin
        rel = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            if (op_is(op[u], OP_FREE) && held[sel[u]] && owner[sel[u]] == UW'(u))
                rel[sel[u]] = 1'b1;
        end
    end

    always_comb begin
        for (int u = 0; u < N_UNITS; u++) begin
            grant_now[u] = op_is(op[u], OP_LOCK) && !held[sel[u]]
                           && win[sel[u]] == UW'(u);
            free_bad[u]  = op_is(op[u], OP_FREE)
                           && !(held[sel[u]] && owner[sel[u]] == UW'(u));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= '0;
            owner     <= '0;
            lock_ok_q <= '0;
        end else begin
            for (int b = 0; b < N_BLOCKS; b++) begin
                if (held[b]) begin
                    if (rel[b]) held[b] <= 1'b0;
                end else if (any_req[b]) begin
                    held[b]  <= 1'b1;
                    owner[b] <= win[b];
                end
            end
            lock_ok_q <= grant_now;
        end
    end

endmodule

// File: rtl/sem_xbar_ram.sv
module sem_xbar_ram #(
    parameter int AW = 6,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end

endmodule

// File: rtl/sem_xbar_unit_port.sv
module sem_xbar_unit_port
    import sem_xbar_pkg::*;
#(
    parameter int N_UNITS  = 4,
    parameter int N_BLOCKS = 8,
    parameter int DATA_W   = 32,
    parameter int UNIT_ID  = 0,
    localparam int UW = $clog2(N_UNITS),
    localparam int SW = $clog2(N_BLOCKS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [1:0]                       op,
    input  logic [SW-1:0]                    sel,
    input  logic                             we,
    input  logic [N_BLOCKS-1:0]              held,
    input  logic [N_BLOCKS-1:0][UW-1:0]      owner,
    input  logic                             free_bad,
    input  logic [N_BLOCKS-1:0][DATA_W-1:0]  blk_rdata,
    output logic                             acc_go,
    output logic                             lock_ack,
    output logic                             prot_err,
    output logic                             rd_valid,
    output logic [DATA_W-1:0]                rd_data
);

    logic          owns;
    logic          acc_bad;
    logic [SW-1:0] sel_q;

    assign owns    = held[sel] && owner[sel] == UW'(UNIT_ID);
    assign acc_go  = op_is(op, OP_ACCESS) && owns;
    assign acc_bad = op_is(op, OP_ACCESS) && !owns;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_ack <= 1'b0;
            prot_err <= 1'b0;
            rd_valid <= 1'b0;
            sel_q    <= '0;
        end else begin
            lock_ack <= op_is(op, OP_LOCK);
            prot_err <= acc_bad || free_bad;
            rd_valid <= acc_go && !we;
            sel_q    <= sel;
        end
    end

    // Return path steered by the block select registered with the request
    assign rd_data = rd_valid ? blk_rdata[sel_q] : '0;

endmodule

// File: rtl/sem_xbar.sv
module sem_xbar
    import sem_xbar_pkg::*;
#(
    parameter int N_UNITS  = 4,
    parameter int N_BLOCKS = 8,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int MEM_AW   = 6,
    localparam int UW = $clog2(N_UNITS),
    localparam int SW = $clog2(N_BLOCKS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_UNITS-1:0][1:0]         unit_op,
    input  logic [N_UNITS-1:0][SW-1:0]      unit_sel,
    input  logic [N_UNITS-1:0][ADDR_W-1:0]  unit_addr,
    input  logic [N_UNITS-1:0]              unit_we,
    input  logic [N_UNITS-1:0][DATA_W-1:0]  unit_wdata,
    output logic [N_UNITS-1:0]              lock_ack,
    output logic [N_UNITS-1:0]              lock_ok,
    output logic [N_UNITS-1:0]              prot_err,
    output logic [N_UNITS-1:0]              rd_valid,
    output logic [N_UNITS-1:0][DATA_W-1:0]  rd_data
);

    typedef struct packed {
        logic              en;
        logic              we;
        logic [MEM_AW-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } blk_port_t;

    logic [N_BLOCKS-1:0]              sem_held;
    logic [N_BLOCKS-1:0][UW-1:0]      sem_owner;
    logic [N_UNITS-1:0]               free_bad;
    logic [N_UNITS-1:0]               acc_go;
    logic [N_BLOCKS-1:0][DATA_W-1:0]  blk_rdata;
    blk_port_t [N_BLOCKS-1:0]         bport;

    sem_xbar_sem_bank #(
        .N_UNITS (N_UNITS),
        .N_BLOCKS(N_BLOCKS)
    ) u_sem (
        .clk      (clk),
        .rst      (rst),
        .op       (unit_op),
        .sel      (unit_sel),
        .held     (sem_held),
        .owner    (sem_owner),
        .lock_ok_q(lock_ok),
        .free_bad (free_bad)
    );

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        sem_xbar_unit_port #(
            .N_UNITS (N_UNITS),
            .N_BLOCKS(N_BLOCKS),
            .DATA_W  (DATA_W),
            .UNIT_ID (u)
        ) u_port (
            .clk      (clk),
            .rst      (rst),
            .op       (unit_op[u]),
            .sel      (unit_sel[u]),
            .we       (unit_we[u]),
            .held     (sem_held),
            .owner    (sem_owner),
            .free_bad (free_bad[u]),
            .blk_rdata(blk_rdata),
            .acc_go   (acc_go[u]),
            .lock_ack (lock_ack[u]),
            .prot_err (prot_err[u]),
            .rd_valid (rd_valid[u]),
            .rd_data  (rd_data[u])
        );
    end

    // Each block listens only to its current holder
    always_comb begin
        for (int b = 0; b < N_BLOCKS; b++) begin
            bport[b].en    = sem_held[b] && acc_go[sem_owner[b]]
                             && unit_sel[sem_owner[b]] == SW'(b);
            bport[b].we    = bport[b].en && unit_we[sem_owner[b]];
            bport[b].addr  = unit_addr[sem_owner[b]][MEM_AW-1:0];
            bport[b].wdata = unit_wdata[sem_owner[b]];
        end
    end

    for (genvar b = 0; b < N_BLOCKS; b++) begin : g_blk
        sem_xbar_ram #(
            .AW(MEM_AW),
            .DW(DATA_W)
        ) u_ram (
            .clk  (clk),
            .en   (bport[b].en),
            .we   (bport[b].we),
            .addr (bport[b].addr),
            .wdata(bport[b].wdata),
            .rdata(blk_rdata[b])
        );
    end

endmodule

// File: rtl/sem_xbar_chk.sv
module sem_xbar_chk
    import sem_xbar_pkg::*;
#(
    parameter int N_UNITS  = 4,
    parameter int N_BLOCKS = 8,
    localparam int UW = $clog2(N_UNITS),
    localparam int SW = $clog2(N_BLOCKS)
) (
    input logic                        clk,
    input logic                        rst,
    input logic [N_UNITS-1:0][1:0]     op,
    input logic [N_UNITS-1:0][SW-1:0]  sel,
    input logic [N_UNITS-1:0]          we,
    input logic [N_BLOCKS-1:0]         held,
    input logic [N_BLOCKS-1:0][UW-1:0] owner,
    input logic [N_UNITS-1:0]          lock_ok,
    input logic [N_UNITS-1:0]          prot_err,
    input logic [N_UNITS-1:0]          rd_valid
);

    logic [N_UNITS-1:0]  ahead;
    logic [N_UNITS-1:0]  mine;
    logic [N_BLOCKS-1:0] holder_frees;

    always_comb begin
        ahead        = '0;
        holder_frees = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            mine[u] = held[sel[u]] && owner[sel[u]] == UW'(u);
            for (int w = 0; w < u; w++) begin
                if (op[w] == OP_LOCK && op[u] == OP_LOCK && sel[w] == sel[u])
                    ahead[u] = 1'b1;
            end
            if (op[u] == OP_FREE && mine[u]) holder_frees[sel[u]] = 1'b1;
        end
    end

    for (genvar u = 0; u < N_UNITS; u++) begin : g_u
        assert_free_lock_wins_R2: assert property (@(posedge clk) disable iff (rst)
            (op[u] == OP_LOCK && !held[sel[u]] && !ahead[u]) |=> lock_ok[u]);
        assert_held_lock_fails_R3: assert property (@(posedge clk) disable iff (rst)
            (op[u] == OP_LOCK && held[sel[u]]) |=> !lock_ok[u]);
        assert_tie_loser_R4: assert property (@(posedge clk) disable iff (rst)
            (op[u] == OP_LOCK && ahead[u]) |=> !lock_ok[u]);
        assert_owner_read_R6: assert property (@(posedge clk) disable iff (rst)
            (op[u] == OP_ACCESS && mine[u] && !we[u]) |=> (rd_valid[u] && !prot_err[u]));
        assert_foreign_access_R7: assert property (@(posedge clk) disable iff (rst)
            (op[u] == OP_ACCESS && !mine[u]) |=> (prot_err[u] && !rd_valid[u]));
    end

    for (genvar b = 0; b < N_BLOCKS; b++) begin : g_b
        assert_holder_kept_R5: assert property (@(posedge clk) disable iff (rst)
            (held[b] && !holder_frees[b]) |=> (held[b] && $stable(owner[b])));
        assert_release_R5: assert property (@(posedge clk) disable iff (rst)
            holder_frees[b] |=> !held[b]);
    end

endmodule

bind sem_xbar sem_xbar_chk #(
    .N_UNITS (N_UNITS),
    .N_BLOCKS(N_BLOCKS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op      (unit_op),
    .sel     (unit_sel),
    .we      (unit_we),
    .held    (sem_held),
    .owner   (sem_owner),
    .lock_ok (lock_ok),
    .prot_err(prot_err),
    .rd_valid(rd_valid)
);

// File: tb/tb_sem_xbar.sv
module tb_sem_xbar;

    localparam int NU = 4;
    localparam int NB = 8;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NV = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NU-1:0][1:0]    op;
    logic [NU-1:0][2:0]    sel;
    logic [NU-1:0][AW-1:0] addr;
    logic [NU-1:0]         we;
    logic [NU-1:0][DW-1:0] wdata;
    logic [NU-1:0]         lock_ack, lock_ok, prot_err, rd_valid;
    logic [NU-1:0][DW-1:0] rd_data;

    sem_xbar dut (
        .clk(clk), .rst(rst),
        .unit_op(op), .unit_sel(sel), .unit_addr(addr),
        .unit_we(we), .unit_wdata(wdata),
        .lock_ack(lock_ack), .lock_ok(lock_ok), .prot_err(prot_err),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [3:0][1:0] op;
        logic [3:0][2:0] sel;
        logic [3:0]      we;
        logic [3:0]      ok;
        logic [3:0]      err;
    } vec_t;

    // Unit order in each field: unit3 .. unit0. Ops: 0 idle, 1 lock, 2 free, 3 access
    localparam vec_t VT [NV] = '{
        '{ {2'd0,2'd0,2'd1,2'd1}, {3'd0,3'd0,3'd2,3'd2}, 4'b0000, 4'b0001, 4'b0000 },
        '{ {2'd0,2'd0,2'd1,2'd0}, {3'd0,3'd0,3'd2,3'd0}, 4'b0000, 4'b0000, 4'b0000 },
        '{ {2'd0,2'd0,2'd3,2'd0}, {3'd0,3'd0,3'd2,3'd0}, 4'b0010, 4'b0000, 4'b0010 },
        '{ {2'd0,2'd0,2'd2,2'd0}, {3'd0,3'd0,3'd2,3'd0}, 4'b0000, 4'b0000, 4'b0010 },
        '{ {2'd1,2'd1,2'd1,2'd2}, {3'd5,3'd5,3'd5,3'd2}, 4'b0000, 4'b0010, 4'b0000 },
        '{ {2'd0,2'd1,2'd0,2'd1}, {3'd0,3'd5,3'd0,3'd2}, 4'b0000, 4'b0001, 4'b0000 },
        '{ {2'd1,2'd1,2'd1,2'd1}, {3'd7,3'd7,3'd7,3'd7}, 4'b0000, 4'b0001, 4'b0000 },
        '{ {2'd1,2'd1,2'd0,2'd0}, {3'd0,3'd1,3'd0,3'd0}, 4'b0000, 4'b1100, 4'b0000 },
        '{ {2'd3,2'd0,2'd3,2'd3}, {3'd0,3'd0,3'd0,3'd7}, 4'b1011, 4'b0000, 4'b0010 },
        '{ {2'd2,2'd2,2'd2,2'd2}, {3'd0,3'd1,3'd5,3'd7}, 4'b0000, 4'b0000, 4'b0000 },
        '{ {2'd0,2'd0,2'd0,2'd2}, {3'd0,3'd0,3'd0,3'd2}, 4'b0000, 4'b0000, 4'b0000 },
        '{ {2'd0,2'd2,2'd0,2'd0}, {3'd0,3'd2,3'd0,3'd0}, 4'b0000, 4'b0000, 4'b0100 },
        '{ {2'd1,2'd3,2'd0,2'd0}, {3'd3,3'd3,3'd0,3'd0}, 4'b0000, 4'b1000, 4'b0100 },
        '{ {2'd2,2'd0,2'd0,2'd0}, {3'd3,3'd0,3'd0,3'd0}, 4'b0000, 4'b0000, 4'b0000 }
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_all;
        op = '0; sel = '0; addr = '0; we = '0; wdata = '0;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input int u, input logic [1:0] o, input logic [2:0] s,
                         input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
        op[u] = o; sel[u] = s; addr[u] = a; we[u] = w; wdata[u] = d;
    endtask

    initial begin
        logic [3:0] exp_ack, exp_rv;
        idle_all();
        repeat (3) tick();
        chk("R1 outputs in reset", {lock_ack, lock_ok, prot_err, rd_valid}, 16'h0);
        rst = 1'b0;
        tick();
        chk("R1 outputs after reset", {lock_ack, lock_ok, prot_err, rd_valid}, 16'h0);
        // lowest-priority unit can claim every block after reset
        for (int b = 0; b < NB; b++) begin
            drive(3, 2'd1, 3'(b), '0, 1'b0, '0);
            tick();
            chk($sformatf("R1 R10 lock block %0d", b), lock_ok, 4'b1000);
            idle_all();
        end
        for (int b = 0; b < NB; b++) begin
            drive(3, 2'd2, 3'(b), '0, 1'b0, '0);
            tick();
            chk($sformatf("R5 holder free block %0d", b), prot_err, 4'b0000);
            idle_all();
        end

        // table walk: lock contention, releases, foreign accesses
        for (int i = 0; i < NV; i++) begin
            op  = VT[i].op;
            sel = VT[i].sel;
            we  = VT[i].we;
            for (int u = 0; u < NU; u++) begin
                addr[u]  = AW'(i);
                wdata[u] = {8'(u), 24'(i)};
            end
            for (int u = 0; u < NU; u++) begin
                exp_ack[u] = (VT[i].op[u] == 2'd1);
                exp_rv[u]  = (VT[i].op[u] == 2'd3) && !VT[i].we[u] && !VT[i].err[u];
            end
            tick();
            chk($sformatf("R2 R3 R4 lock_ok vec %0d", i), lock_ok, VT[i].ok);
            chk($sformatf("R2 lock_ack vec %0d", i), lock_ack, exp_ack);
            chk($sformatf("R5 R7 prot_err vec %0d", i), prot_err, VT[i].err);
            chk($sformatf("R6 R7 rd_valid vec %0d", i), rd_valid, exp_rv);
            idle_all();
        end

        // concurrent claims of distinct blocks
        drive(0, 2'd1, 3'd4, '0, 1'b0, '0);
        drive(1, 2'd1, 3'd6, '0, 1'b0, '0);
        tick();
        chk("R8 R10 distinct claims", lock_ok, 4'b0011);
        idle_all();
        // concurrent writes, upper address bits differ from later reads
        drive(0, 2'd3, 3'd4, 16'h0045, 1'b1, 32'hA5A5_0001);
        drive(1, 2'd3, 3'd6, 16'h0005, 1'b1, 32'h5A5A_0002);
        tick();
        chk("R8 concurrent writes no error", prot_err, 4'b0000);
        idle_all();
        drive(0, 2'd3, 3'd4, 16'hFF05, 1'b0, '0);
        drive(1, 2'd3, 3'd6, 16'h0005, 1'b0, '0);
        tick();
        chk("R8 concurrent read valid", rd_valid, 4'b0011);
        chk("R6 read-back unit0 low address bits", rd_data[0], 32'hA5A5_0001);
        chk("R8 read-back unit1", rd_data[1], 32'h5A5A_0002);
        idle_all();
        // foreign write must not land
        drive(2, 2'd3, 3'd4, 16'h0005, 1'b1, 32'hDEAD_BEEF);
        tick();
        chk("R7 foreign write flagged", prot_err, 4'b0100);
        chk("R7 foreign write no rd_valid", rd_valid, 4'b0000);
        idle_all();
        drive(0, 2'd3, 3'd4, 16'h0005, 1'b0, '0);
        tick();
        chk("R7 holder data intact", rd_data[0], 32'hA5A5_0001);
        idle_all();
        // unit 0 holds a second block
        drive(0, 2'd1, 3'd1, '0, 1'b0, '0);
        tick();
        chk("R9 second block claimed", lock_ok, 4'b0001);
        idle_all();
        drive(0, 2'd3, 3'd1, 16'h0009, 1'b1, 32'h1234_5678);
        tick();
        idle_all();
        drive(0, 2'd3, 3'd1, 16'h0009, 1'b0, '0);
        tick();
        chk("R9 second block data", rd_data[0], 32'h1234_5678);
        idle_all();
        drive(0, 2'd3, 3'd4, 16'h0005, 1'b0, '0);
        tick();
        chk("R9 first block still readable", rd_data[0], 32'hA5A5_0001);
        idle_all();
        // holder relocking its own block fails
        drive(0, 2'd1, 3'd4, '0, 1'b0, '0);
        tick();
        chk("R3 holder relock fails", {lock_ack[0], lock_ok[0]}, 2'b10);
        idle_all();
        // release then another unit claims
        drive(0, 2'd2, 3'd4, '0, 1'b0, '0);
        tick();
        idle_all();
        drive(2, 2'd1, 3'd4, '0, 1'b0, '0);
        tick();
        chk("R5 claim after release", lock_ok, 4'b0100);
        idle_all();
        drive(2, 2'd2, 3'd4, '0, 1'b0, '0);
        drive(0, 2'd2, 3'd1, '0, 1'b0, '0);
        drive(1, 2'd2, 3'd6, '0, 1'b0, '0);
        tick();
        chk("R5 final releases clean", prot_err, 4'b0000);
        idle_all();
        tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule